// File: doc/BRIEF.md
# Data Rate and Power Control Register

This block holds the write-only control byte that a disk controller uses to choose its transfer rate and write precompensation amount, to enter a manual low-power state and to request a software reset. A host writes the byte through a write strobe. A second configuration-control port can also set the rate code. The rate that the rest of the controller sees is the one from whichever port was written last.

A three-state power machine sits beside the stored fields. Its states are RUN (normal operation), SRST (a single cycle in which the software reset pulse is driven) and LPWR (manual low power, with the oscillator and data-separator enables dropped). The machine moves as follows:
- RUN or SRST to SRST on a host write with the reset bit set.
- RUN or SRST to LPWR on a low-power request: a host write with the low-power bit set, or the external low-power command.
- RUN or SRST to RUN otherwise.
- LPWR to SRST on a host write with the reset bit set.
- LPWR to RUN on a data-register or status-register access strobe.
- LPWR stays in LPWR otherwise.

A software reset never alters the stored rate or precompensation fields. The reset bit itself is never stored.

Top module: `rate_pwr_ctl`

## Requirements
- R1: After hardware reset the outputs are rate_code = 2'b10 (250 kbps), precomp_code = 3'b000, low_power = 0, soft_rst = 0, osc_en = 1 and sep_en = 1.
- R2: A host write stores rate_wdata[4:2] into precomp_code and rate_wdata[1:0] into rate_code. Both are visible in the cycle after the strobe. Without a write, both fields hold their values.
- R3: A configuration write sets rate_code from cfg_wdata[1:0] in the next cycle and leaves precomp_code unchanged.
- R4: rate_code follows the most recent write on either port. When both ports write in the same cycle, the configuration port wins.
- R5: A host write with rate_wdata[7] = 1 drives soft_rst high for exactly the following cycle. soft_rst is high only after such a write. The fields carried by that same write are still stored.
- R6: A host write with rate_wdata[6] = 1 and rate_wdata[7] = 0 sets low_power from the next cycle. While low_power is 1, osc_en and sep_en are 0.
- R7: A pulse on lp_cmd enters low power exactly as the low-power bit does.
- R8: In low power, a data_acc or stat_acc strobe clears low_power in the next cycle. The wake takes priority over a low-power request in the same cycle. These strobes have no effect outside low power.
- R9: A software reset request leaves low power. It takes priority over a simultaneous low-power request, so low_power is 0 during the soft_rst pulse and in the cycle after it.
- R10: rate_wdata[5] is ignored: it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| rate_wr | input | 1 | Host write strobe for the control byte |
| rate_wdata | input | 8 | Host write data: [7] reset, [6] low power, [5] ignored, [4:2] precomp, [1:0] rate |
| cfg_wr | input | 1 | Configuration-control port write strobe |
| cfg_wdata | input | 2 | Configuration-control rate code |
| data_acc | input | 1 | Data register access strobe (wake) |
| stat_acc | input | 1 | Status register access strobe (wake) |
| lp_cmd | input | 1 | External low-power command pulse |
| rate_code | output | 2 | Active rate code: 00 500k, 01 300k, 10 250k, 11 1M |
| precomp_code | output | 3 | Precompensation code |
| low_power | output | 1 | Manual low-power flag |
| osc_en | output | 1 | Oscillator enable |
| sep_en | output | 1 | Data-separator enable |
| soft_rst | output | 1 | One-cycle software reset pulse |

## Verification
On every cycle, the assertions check the following:
- a reset pulse has a cause and follows each reset write;
- entry into low power, by the bit or by the command, and the wake on an access strobe;
- the configuration port's priority on the rate code;
- that the precompensation field holds across configuration writes and idle cycles.

Other behaviours show only in the bench's scenarios:
- a reset write also stores its fields;
- the reserved bit is ignored;
- access strobes are ignored outside low power;
- the ordering of mixed reset, low-power and wake requests over long random runs, compared with a bench model.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_SRST = 2'd1,
        PS_LPWR = 2'd2
    } pwr_state_t;

endpackage

// File: rtl/rpc_field_reg.sv
module rpc_field_reg #(
    parameter int          RATE_W       = 2,
    parameter int          PCOMP_W      = 3,
    parameter logic [RATE_W-1:0]  RATE_RST  = 2'b10,
    parameter logic [PCOMP_W-1:0] PCOMP_RST = 3'b000,
    parameter bit          CFG_TIE_WINS = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [RATE_W-1:0]  host_rate,
    input  logic [PCOMP_W-1:0] host_pcomp,
    input  logic               cfg_wr,
    input  logic [RATE_W-1:0]  cfg_rate,
    output logic [RATE_W-1:0]  rate_q,
    output logic [PCOMP_W-1:0] pcomp_q
);

    logic [RATE_W-1:0] rate_nxt;

    // Tie rule between the two rate writers is chosen by parameter.
    generate
        if (CFG_TIE_WINS) begin : g_cfg_first
            always_comb begin
                if (cfg_wr)       rate_nxt = cfg_rate;
                else if (host_wr) rate_nxt = host_rate;
                else              rate_nxt = rate_q;
            end
        end else begin : g_host_first
            always_comb begin
                if (host_wr)      rate_nxt = host_rate;
                else if (cfg_wr)  rate_nxt = cfg_rate;
                else              rate_nxt = rate_q;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q  <= RATE_RST;
            pcomp_q <= PCOMP_RST;
        end else begin
            rate_q <= rate_nxt;
            if (host_wr) pcomp_q <= host_pcomp;
        end
    end

endmodule

// File: rtl/rpc_pwr_fsm.sv
module rpc_pwr_fsm
    import rpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    input  logic lp_req,
    input  logic wake,
    output logic low_power,
    output logic osc_en,
    output logic sep_en,
    output logic soft_rst
);

    pwr_state_t state_q, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PS_RUN, PS_SRST: begin
                if (srst_req)    state_nxt = PS_SRST;
                else if (lp_req) state_nxt = PS_LPWR;
                else             state_nxt = PS_RUN;
            end
            PS_LPWR: begin
                if (srst_req)  state_nxt = PS_SRST;
                else if (wake) state_nxt = PS_RUN;
                else           state_nxt = PS_LPWR;
            end
            default: state_nxt = PS_RUN;
        endcase
    end

    always_comb begin
        low_power = 1'b0;
        soft_rst  = 1'b0;
        osc_en    = 1'b1;
        sep_en    = 1'b1;
        unique case (state_q)
            PS_RUN:  ;
            PS_SRST: soft_rst = 1'b1;
            PS_LPWR: begin
                low_power = 1'b1;
                osc_en    = 1'b0;
                sep_en    = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rate_pwr_ctl.sv
module rate_pwr_ctl #(
    parameter int          REG_W        = 8,
    parameter int          RATE_W       = 2,
    parameter int          PCOMP_W      = 3,
    parameter logic [7:0]  RST_VAL      = 8'h02,
    parameter bit          CFG_TIE_WINS = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rate_wr,
    input  logic [REG_W-1:0]   rate_wdata,
    input  logic               cfg_wr,
    input  logic [RATE_W-1:0]  cfg_wdata,
    input  logic               data_acc,
    input  logic               stat_acc,
    input  logic               lp_cmd,
    output logic [RATE_W-1:0]  rate_code,
    output logic [PCOMP_W-1:0] precomp_code,
    output logic               low_power,
    output logic               osc_en,
    output logic               sep_en,
    output logic               soft_rst
);

    localparam int PC_LSB  = RATE_W;
    localparam int PC_MSB  = RATE_W + PCOMP_W - 1;
    localparam int RSV_BIT = PC_MSB + 1;
    localparam int LP_BIT  = REG_W - 2;
    localparam int SR_BIT  = REG_W - 1;

    logic srst_req, lp_req, wake;
    logic rsvd_unused;

    assign srst_req    = rate_wr & rate_wdata[SR_BIT];
    assign lp_req      = (rate_wr & rate_wdata[LP_BIT]) | lp_cmd;
    assign wake        = data_acc | stat_acc;
    assign rsvd_unused = rate_wdata[RSV_BIT];

    rpc_field_reg #(
        .RATE_W       (RATE_W),
        .PCOMP_W      (PCOMP_W),
        .RATE_RST     (RST_VAL[RATE_W-1:0]),
        .PCOMP_RST    (RST_VAL[PC_MSB:PC_LSB]),
        .CFG_TIE_WINS (CFG_TIE_WINS)
    ) i_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (rate_wr),
        .host_rate  (rate_wdata[RATE_W-1:0]),
        .host_pcomp (rate_wdata[PC_MSB:PC_LSB]),
        .cfg_wr     (cfg_wr),
        .cfg_rate   (cfg_wdata),
        .rate_q     (rate_code),
        .pcomp_q    (precomp_code)
    );

    rpc_pwr_fsm i_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_req  (srst_req),
        .lp_req    (lp_req),
        .wake      (wake),
        .low_power (low_power),
        .osc_en    (osc_en),
        .sep_en    (sep_en),
        .soft_rst  (soft_rst)
    );

endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
    parameter int REG_W        = 8,
    parameter int RATE_W       = 2,
    parameter int PCOMP_W      = 3,
    parameter bit CFG_TIE_WINS = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rate_wr,
    input logic [REG_W-1:0]   rate_wdata,
    input logic               cfg_wr,
    input logic [RATE_W-1:0]  cfg_wdata,
    input logic               data_acc,
    input logic               stat_acc,
    input logic               lp_cmd,
    input logic [RATE_W-1:0]  rate_code,
    input logic [PCOMP_W-1:0] precomp_code,
    input logic               low_power,
    input logic               soft_rst
);

    logic srst_w, lp_w, wake_w;
    assign srst_w = rate_wr && rate_wdata[REG_W-1];
    assign lp_w   = (rate_wr && rate_wdata[REG_W-2]) || lp_cmd;
    assign wake_w = low_power && (data_acc || stat_acc);

    p_srst_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srst_w |=> soft_rst);

    p_srst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(srst_w));

    p_lp_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_wr && rate_wdata[REG_W-2] && !srst_w && !wake_w) |=> low_power);

    p_lp_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_cmd && !srst_w && !wake_w) |=> low_power);

    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_w |=> !low_power);

    p_srst_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !low_power);

    p_cfg_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (CFG_TIE_WINS || !rate_wr)) |=> rate_code == $past(cfg_wdata));

    p_pcomp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_wr |=> $stable(precomp_code));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_wr && !cfg_wr) |=> $stable(rate_code));

    logic lp_unused;
    assign lp_unused = lp_w;

endmodule

bind rate_pwr_ctl rpc_checker #(
    .REG_W        (REG_W),
    .RATE_W       (RATE_W),
    .PCOMP_W      (PCOMP_W),
    .CFG_TIE_WINS (CFG_TIE_WINS)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate_wr      (rate_wr),
    .rate_wdata   (rate_wdata),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .data_acc     (data_acc),
    .stat_acc     (stat_acc),
    .lp_cmd       (lp_cmd),
    .rate_code    (rate_code),
    .precomp_code (precomp_code),
    .low_power    (low_power),
    .soft_rst     (soft_rst)
);

// File: tb/test_rate_pwr_ctl.sv
`timescale 1ns/1ps
module test_rate_pwr_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_wr = 1'b0;
    logic [7:0] rate_wdata = 8'h00;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       data_acc = 1'b0;
    logic       stat_acc = 1'b0;
    logic       lp_cmd = 1'b0;
    logic [1:0] rate_code;
    logic [2:0] precomp_code;
    logic       low_power, osc_en, sep_en, soft_rst;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model state
    logic [1:0] m_rate;
    logic [2:0] m_pc;
    logic       m_lp;
    logic       m_sr;

    always #5 clk = ~clk;

    rate_pwr_ctl i_rate_pwr_ctl (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .data_acc(data_acc),
        .stat_acc(stat_acc), .lp_cmd(lp_cmd), .rate_code(rate_code),
        .precomp_code(precomp_code), .low_power(low_power), .osc_en(osc_en),
        .sep_en(sep_en), .soft_rst(soft_rst)
    );

    function automatic logic [1:0] f_rate(logic [1:0] cur, logic hw, logic [7:0] hd,
                                          logic cw, logic [1:0] cd);
        if (cw)      return cd;     // R4: configuration port wins a tie
        else if (hw) return hd[1:0];
        return cur;
    endfunction

    function automatic logic f_lp(logic cur, logic hw, logic [7:0] hd,
                                  logic acc, logic cmd);
        if (hw && hd[7])           return 1'b0;   // R9
        if (cur)                   return !acc;   // R8
        if ((hw && hd[6]) || cmd)  return 1'b1;   // R6, R7
        return 1'b0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        m_sr   = rate_wr && rate_wdata[7];
        m_lp   = f_lp(m_lp, rate_wr, rate_wdata, data_acc || stat_acc, lp_cmd);
        m_rate = f_rate(m_rate, rate_wr, rate_wdata, cfg_wr, cfg_wdata);
        if (rate_wr) m_pc = rate_wdata[4:2];
        @(negedge clk);
        rate_wr = 0; cfg_wr = 0; data_acc = 0; stat_acc = 0; lp_cmd = 0;
        chk(tag, "rate_code", rate_code, m_rate);
        chk(tag, "precomp_code", precomp_code, m_pc);
        chk(tag, "low_power", low_power, m_lp);
        chk(tag, "soft_rst", soft_rst, m_sr);
        chk(tag, "osc_en", osc_en, !m_lp);
        chk(tag, "sep_en", sep_en, !m_lp);
    endtask

    task automatic hwr(logic [7:0] d);
        rate_wr = 1'b1; rate_wdata = d;
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_rate = 2'b10; m_pc = 3'b000; m_lp = 1'b0; m_sr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1", "rate_code", rate_code, 2);
        chk("R1", "precomp_code", precomp_code, 0);
        chk("R1", "low_power", low_power, 0);
        chk("R1", "soft_rst", soft_rst, 0);
        chk("R1", "osc_en", osc_en, 1);
        chk("R1", "sep_en", sep_en, 1);

        // R2 host write of fields, then idle hold
        hwr(8'h1D); cyc("R2");
        chk("R2", "precomp literal", precomp_code, 7);
        chk("R2", "rate literal", rate_code, 1);
        cyc("R2");
        // R10 reserved bit ignored
        hwr(8'h20); cyc("R10");
        chk("R10", "rate after 20h", rate_code, 0);
        chk("R10", "low_power after 20h", low_power, 0);
        hwr(8'h2F); cyc("R10");
        chk("R10", "precomp after 2Fh", precomp_code, 3);
        // R3 configuration write
        cfg_wr = 1; cfg_wdata = 2'b01; cyc("R3");
        chk("R3", "precomp kept", precomp_code, 3);
        // R4 tie and last writer
        hwr(8'h03); cfg_wr = 1; cfg_wdata = 2'b10; cyc("R4");
        chk("R4", "tie rate", rate_code, 2);
        hwr(8'h03); cyc("R4");
        chk("R4", "host latest", rate_code, 3);
        // R5 soft reset pulse, fields still stored
        hwr(8'h95); cyc("R5");
        chk("R5", "pulse", soft_rst, 1);
        chk("R5", "rate stored", rate_code, 1);
        cyc("R5");
        chk("R5", "pulse ends", soft_rst, 0);
        // R8 strobes ignored outside low power
        data_acc = 1; stat_acc = 1; cyc("R8");
        // R6 enter by bit, stay, wake by data access
        hwr(8'h42); cyc("R6");
        chk("R6", "low_power", low_power, 1);
        chk("R6", "osc_en", osc_en, 0);
        hwr(8'h40); cyc("R6");
        data_acc = 1; lp_cmd = 1; cyc("R8");
        chk("R8", "wake over request", low_power, 0);
        // R7 command entry, wake by status access
        lp_cmd = 1; cyc("R7");
        chk("R7", "low_power", low_power, 1);
        stat_acc = 1; cyc("R8");
        chk("R8", "status wake", low_power, 0);
        // R9 reset exits and beats low-power bit
        lp_cmd = 1; cyc("R9");
        hwr(8'hC0); cyc("R9");
        chk("R9", "low_power in pulse", low_power, 0);
        cyc("R9");
        chk("R9", "low_power after pulse", low_power, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            rate_wr    = ($urandom % 4) == 0;
            rate_wdata = 8'($urandom) & ((($urandom % 8) == 0) ? 8'hFF : 8'h7F);
            cfg_wr     = ($urandom % 5) == 0;
            cfg_wdata  = 2'($urandom);
            data_acc   = ($urandom % 6) == 0;
            stat_acc   = ($urandom % 8) == 0;
            lp_cmd     = ($urandom % 12) == 0;
            cyc("R4 R6 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog (all requirements): actual hung, expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule